// File: doc/BRIEF.md
# Multiplexed LCD Frame Sequencer

This block orders the common-electrode phases of a multiplexed segment display. A phase tick from a prescaler moves it one phase on. The duty code sets how many common phases make up a frame. Frames come in pairs of opposite drive polarity, so the mean voltage on every pixel is zero. After each pair the sequencer can hold the display idle for a programmable number of dead phases.

Pixel data is written into a write buffer, one row per common phase. An update request copies the whole buffer into the display buffer. The copy happens at the next frame start, so a frame never shows a mix of old and new rows. The segment output carries the row of the active common phase. A blink state, toggled by an external blink tick, blanks a chosen subset of pixels. Sticky start-of-frame and update-done flags, each with its own enable, feed one interrupt line. An enabled-status output shows whether frames are being produced.

Top module: `lcd_frame_seq`

## Requirements
- R1: The duty code sets the number of common phases per frame: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 3, 3'b011 gives 4, 3'b100 gives 8, and any other code gives 1. While running, `com_idx` steps 0,1,…,N-1 by one on each `phase_tick` and `com_act` is high.
- R2: The duty and dead-time codes are sampled only at frame start. A change in mid-frame takes effect from the next frame.
- R3: `polarity` is 0 in the first frame after enable and after a dead gap, and it inverts at each frame start within a pair. When a frame with polarity 1 ends and the sampled dead code D (3 bits) is non-zero, D ticks of dead phases follow. During them `com_act` is low and `seg_out` is zero.
- R4: `sof_flag` is set in the same cycle in which a frame's phase 0 first appears. It stays set until `sof_clr` is high; a set in the same cycle wins over the clear.
- R5: When `enable` is high while `ens` is low, `ens` rises on the next clock edge and a frame starts at phase 0 with polarity 0.
- R6: When `enable` drops, `ens` stays high and frames continue until the tick that ends the current frame or dead gap. Then `ens` and `com_act` go low.
- R7: `blink_tick` toggles a blank state, which reset clears. While the state is blank, `blink_mode` 2'b01 forces segment 0 off in phase 0 only, 2'b10 forces segment 0 off in every phase, and 2'b11 forces all segments off. 2'b00 forces none.
- R8: `upd_req` sets `upd_pend`. At the next frame start the write buffer is copied to the display buffer, `upd_pend` clears and `udd_flag` sets. `udd_flag` is sticky until `udd_clr`. Writes to the buffer do not change `seg_out` before that copy.
- R9: A request made while `ens` is low does not complete: `udd_flag` stays low and `upd_pend` stays high.
- R10: `irq` is high exactly when (`sof_flag` and `sof_ie`) or (`udd_flag` and `udd_ie`).
- R11: After reset `ens`, `com_act`, `seg_out`, `sof_flag`, `udd_flag`, `upd_pend` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request |
| phase_tick | input | 1 | One-cycle pulse advancing one phase |
| blink_tick | input | 1 | One-cycle pulse toggling the blank state |
| duty_sel | input | 3 | Duty code |
| dead_sel | input | 3 | Dead phases after each frame pair |
| blink_mode | input | 2 | Pixel subset that blinks |
| wr_en | input | 1 | Write buffer row write strobe |
| wr_row | input | 3 | Row (common phase) written |
| wr_data | input | SEG_W | Row pixel data |
| upd_req | input | 1 | Display update request pulse |
| sof_clr | input | 1 | Clear start-of-frame flag |
| udd_clr | input | 1 | Clear update-done flag |
| sof_ie | input | 1 | Start-of-frame interrupt enable |
| udd_ie | input | 1 | Update-done interrupt enable |
| com_idx | output | 3 | Active common phase |
| com_act | output | 1 | A common phase is being driven |
| polarity | output | 1 | Drive polarity of the current frame |
| seg_out | output | SEG_W | Segment data for the active phase |
| sof_flag | output | 1 | Sticky start-of-frame flag |
| udd_flag | output | 1 | Sticky update-done flag |
| upd_pend | output | 1 | Update request waiting for frame start |
| ens | output | 1 | Sequencer running status |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong phase counter shows on `com_idx` at the next tick. A wrong pair or dead-gap count shows within one frame pair, through `polarity` and a `com_act` gap in the wrong place. A lost or early buffer copy shows on `seg_out` at the first phase of the frame where the new rows should appear, together with `udd_flag` and `upd_pend`. A stale blank state shows only in the pixels chosen by the blink mode, so every mode is run with the state both blank and clear. A reference model compares all outputs on every cycle, so any divergence is reported in the cycle it first reaches a port.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int MAX_COM = 8;
  localparam int COM_W   = 3;
  localparam int CNT_W   = 4;

  // number of common phases per frame for a duty code
  function automatic logic [CNT_W-1:0] duty_phases(input logic [2:0] code);
    case (code)
      3'b000:  duty_phases = 4'd1;
      3'b001:  duty_phases = 4'd2;
      3'b010:  duty_phases = 4'd3;
      3'b011:  duty_phases = 4'd4;
      3'b100:  duty_phases = 4'd8;
      default: duty_phases = 4'd1;
    endcase
  endfunction

  // is pixel (com, seg s) part of the blinking subset
  function automatic logic blink_hit(input logic [1:0] mode,
                                     input logic [COM_W-1:0] com, input int s);
    case (mode)
      2'b01:   blink_hit = (s == 0) && (com == '0);
      2'b10:   blink_hit = (s == 0);
      2'b11:   blink_hit = 1'b1;
      default: blink_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lcd_phase_ctrl.sv
module lcd_phase_ctrl
  import lcd_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             phase_tick,
  input  logic [2:0]       duty_sel,
  input  logic [2:0]       dead_sel,
  output logic [COM_W-1:0] com_idx,
  output logic             com_act,
  output logic             polarity,
  output logic             ens,
  output logic             frame_start
);
  logic             ens_q, par_q, dead_q;
  logic [COM_W-1:0] com_q;
  logic [2:0]       left_q, d_q;
  logic [CNT_W-1:0] n_q;
  logic             last_phase, gap_end, stop_evt, enter_dead;

  assign last_phase = ({1'b0, com_q} == (n_q - 4'd1));
  assign gap_end    = dead_q && (left_q == 3'd1);
  assign enter_dead = ens_q && phase_tick && enable && !dead_q && last_phase
                      && par_q && (d_q != 3'd0);
  assign frame_start = (!ens_q && enable) ||
                       (ens_q && phase_tick && enable &&
                        (gap_end || (!dead_q && last_phase && !(par_q && (d_q != 3'd0)))));
  assign stop_evt    = ens_q && phase_tick && !enable && (gap_end || (!dead_q && last_phase));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ens_q  <= 1'b0;
      com_q  <= '0;
      par_q  <= 1'b0;
      dead_q <= 1'b0;
      left_q <= '0;
      n_q    <= 4'd1;
      d_q    <= '0;
    end else if (frame_start) begin
      ens_q  <= 1'b1;
      com_q  <= '0;
      par_q  <= (ens_q && !dead_q) ? ~par_q : 1'b0;
      dead_q <= 1'b0;
      n_q    <= duty_phases(duty_sel);
      d_q    <= dead_sel;
    end else if (stop_evt) begin
      ens_q  <= 1'b0;
      com_q  <= '0;
      par_q  <= 1'b0;
      dead_q <= 1'b0;
    end else if (enter_dead) begin
      dead_q <= 1'b1;
      left_q <= d_q;
    end else if (ens_q && phase_tick) begin
      if (dead_q) left_q <= left_q - 3'd1;
      else        com_q  <= com_q + 3'd1;
    end
  end

  assign com_idx  = com_q;
  assign com_act  = ens_q && !dead_q;
  assign polarity = par_q;
  assign ens      = ens_q;

  a_r1_com_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (ens_q && phase_tick && !dead_q && !last_phase) |=> (com_idx == 3'($past(com_idx) + 3'd1)));
  a_r5_enable_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!ens_q && enable) |=> (ens && com_act && com_idx == '0 && !polarity));
  a_r3_gap_resets_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_tick && enable && gap_end) |=> (!polarity && com_act));
  a_r6_ens_holds_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ens_q && !phase_tick) |=> ens);
endmodule

// File: rtl/lcd_disp_buf.sv
module lcd_disp_buf
  import lcd_seq_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [COM_W-1:0] wr_row,
  input  logic [SEG_W-1:0] wr_data,
  input  logic             upd_req,
  input  logic             frame_start,
  input  logic [COM_W-1:0] rd_row,
  output logic [SEG_W-1:0] rd_data,
  output logic             upd_pend,
  output logic             copy_evt
);
  logic [SEG_W-1:0] wbuf_q [MAX_COM];
  logic [SEG_W-1:0] disp_q [MAX_COM];
  logic             pend_q;

  assign copy_evt = frame_start && pend_q;

  for (genvar r = 0; r < MAX_COM; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wbuf_q[r] <= '0;
        disp_q[r] <= '0;
      end else begin
        if (copy_evt) disp_q[r] <= wbuf_q[r];
        if (wr_en && (wr_row == COM_W'(r))) wbuf_q[r] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (upd_req)  pend_q <= 1'b1;
    else if (copy_evt) pend_q <= 1'b0;
  end

  assign rd_data  = disp_q[rd_row];
  assign upd_pend = pend_q;

  a_r8_copy_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_evt && !upd_req) |=> !upd_pend);
  a_r9_pend_waits_for_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pend && !frame_start) |=> upd_pend);
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive
  import lcd_seq_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blink_tick,
  input  logic [1:0]       blink_mode,
  input  logic [COM_W-1:0] com_idx,
  input  logic             com_act,
  input  logic [SEG_W-1:0] row_data,
  output logic [SEG_W-1:0] seg_out
);
  logic blank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          blank_q <= 1'b0;
    else if (blink_tick) blank_q <= ~blank_q;
  end

  for (genvar s = 0; s < SEG_W; s++) begin : g_seg
    assign seg_out[s] = com_act && row_data[s] && !(blank_q && blink_hit(blink_mode, com_idx, s));
  end

  a_r3_idle_is_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !com_act |-> (seg_out == '0));
  a_r7_clear_state_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (com_act && !blank_q) |-> (seg_out == row_data));
endmodule

// File: rtl/lcd_flags.sv
module lcd_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic copy_evt,
  input  logic sof_clr,
  input  logic udd_clr,
  input  logic sof_ie,
  input  logic udd_ie,
  output logic sof_flag,
  output logic udd_flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_flag <= 1'b0;
      udd_flag <= 1'b0;
    end else begin
      sof_flag <= frame_start || (sof_flag && !sof_clr);
      udd_flag <= copy_evt    || (udd_flag && !udd_clr);
    end
  end

  assign irq = (sof_flag && sof_ie) || (udd_flag && udd_ie);

  a_r4_sof_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_flag && !sof_clr) |=> sof_flag);
  a_r8_udd_needs_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(udd_flag) |-> $past(copy_evt));
endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
  import lcd_seq_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             phase_tick,
  input  logic             blink_tick,
  input  logic [2:0]       duty_sel,
  input  logic [2:0]       dead_sel,
  input  logic [1:0]       blink_mode,
  input  logic             wr_en,
  input  logic [2:0]       wr_row,
  input  logic [SEG_W-1:0] wr_data,
  input  logic             upd_req,
  input  logic             sof_clr,
  input  logic             udd_clr,
  input  logic             sof_ie,
  input  logic             udd_ie,
  output logic [2:0]       com_idx,
  output logic             com_act,
  output logic             polarity,
  output logic [SEG_W-1:0] seg_out,
  output logic             sof_flag,
  output logic             udd_flag,
  output logic             upd_pend,
  output logic             ens,
  output logic             irq
);
  logic             frame_start, copy_evt;
  logic [SEG_W-1:0] row_data;

  lcd_phase_ctrl u_phase (
    .clk(clk), .rst_n(rst_n), .enable(enable), .phase_tick(phase_tick),
    .duty_sel(duty_sel), .dead_sel(dead_sel), .com_idx(com_idx),
    .com_act(com_act), .polarity(polarity), .ens(ens), .frame_start(frame_start)
  );

  lcd_disp_buf #(.SEG_W(SEG_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .upd_req(upd_req), .frame_start(frame_start), .rd_row(com_idx),
    .rd_data(row_data), .upd_pend(upd_pend), .copy_evt(copy_evt)
  );

  lcd_seg_drive #(.SEG_W(SEG_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .blink_tick(blink_tick), .blink_mode(blink_mode),
    .com_idx(com_idx), .com_act(com_act), .row_data(row_data), .seg_out(seg_out)
  );

  lcd_flags u_flags (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .copy_evt(copy_evt),
    .sof_clr(sof_clr), .udd_clr(udd_clr), .sof_ie(sof_ie), .udd_ie(udd_ie),
    .sof_flag(sof_flag), .udd_flag(udd_flag), .irq(irq)
  );

  a_r4_sof_with_phase0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (sof_flag && com_act && com_idx == 3'd0));
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sof_flag || udd_flag));
endmodule

// File: tb/lcd_frame_seq_tb_top.sv
`timescale 1ns/1ps
module lcd_frame_seq_tb_top;
  localparam int SEG_W = 16;

  logic clk = 0, rst_n = 0;
  logic enable = 0, phase_tick = 0, blink_tick = 0;
  logic [2:0] duty_sel = 0, dead_sel = 0;
  logic [1:0] blink_mode = 0;
  logic wr_en = 0; logic [2:0] wr_row = 0; logic [SEG_W-1:0] wr_data = 0;
  logic upd_req = 0, sof_clr = 0, udd_clr = 0, sof_ie = 0, udd_ie = 0;
  logic [2:0] com_idx; logic com_act, polarity;
  logic [SEG_W-1:0] seg_out;
  logic sof_flag, udd_flag, upd_pend, ens, irq;

  lcd_frame_seq #(.SEG_W(SEG_W)) dut_i (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0, cmp_on = 0;

  // reference model state
  bit m_ens, m_par, m_dead, m_blank, m_pend, m_sof, m_udd;
  int m_com, m_left, m_n, m_d;
  int m_wbuf[8], m_disp[8];

  function automatic int phases_of(int code);
    int tbl[5] = '{1, 2, 3, 4, 8};
    return (code < 5) ? tbl[code] : 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ens = 0; m_par = 0; m_dead = 0; m_blank = 0; m_pend = 0; m_sof = 0; m_udd = 0;
      m_com = 0; m_left = 0; m_n = 1; m_d = 0;
      for (int i = 0; i < 8; i++) begin m_wbuf[i] = 0; m_disp[i] = 0; end
    end else begin
      bit st, sp, cp, np;
      st = 0; sp = 0; cp = 0;
      np = (m_ens && !m_dead) ? !m_par : 0;
      if (!m_ens) begin
        if (enable) st = 1;
      end else if (phase_tick) begin
        if (m_dead) begin
          if (m_left == 1) begin if (enable) st = 1; else sp = 1; end
          else m_left--;
        end else if (m_com == m_n - 1) begin
          if (!enable) sp = 1;
          else if (m_par && m_d > 0) begin m_dead = 1; m_left = m_d; end
          else st = 1;
        end else m_com++;
      end
      if (st) begin
        cp = m_pend;
        if (cp) for (int i = 0; i < 8; i++) m_disp[i] = m_wbuf[i];
        m_ens = 1; m_com = 0; m_par = np; m_dead = 0;
        m_n = phases_of(duty_sel); m_d = dead_sel;
      end
      if (sp) begin m_ens = 0; m_com = 0; m_par = 0; m_dead = 0; end
      if (upd_req) m_pend = 1; else if (cp) m_pend = 0;
      m_sof = st ? 1 : (sof_clr ? 0 : m_sof);
      m_udd = cp ? 1 : (udd_clr ? 0 : m_udd);
      if (wr_en) m_wbuf[wr_row] = wr_data;
      if (blink_tick) m_blank = !m_blank;
    end
  end

  function automatic int exp_seg();
    int v;
    if (!m_ens || m_dead) return 0;
    v = m_disp[m_com];
    if (m_blank) begin
      if (blink_mode == 2'b01 && m_com == 0) v[0] = 0;
      else if (blink_mode == 2'b10) v[0] = 0;
      else if (blink_mode == 2'b11) v = 0;
    end
    return v;
  endfunction

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0h exp=%0h at t=%0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      bit act;
      act = m_ens && !m_dead;
      chk("R1 com_act", com_act, act);
      if (act) chk("R1 com_idx", com_idx, m_com);
      chk("R3 polarity", polarity, m_par);
      chk("R7 seg_out", seg_out, exp_seg());
      chk("R4 sof_flag", sof_flag, m_sof);
      chk("R8 udd_flag", udd_flag, m_udd);
      chk("R8 upd_pend", upd_pend, m_pend);
      chk("R6 ens", ens, m_ens);
      chk("R10 irq", irq, (m_sof && sof_ie) || (m_udd && udd_ie));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic tick();
    @(posedge clk); #1 phase_tick = 1;
    @(posedge clk); #1 phase_tick = 0;
  endtask
  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin tick(); cyc(gap); end
  endtask
  task automatic blink();
    @(posedge clk); #1 blink_tick = 1;
    @(posedge clk); #1 blink_tick = 0;
  endtask
  task automatic wr(int r, int d);
    @(posedge clk); #1 wr_en = 1; wr_row = 3'(r); wr_data = SEG_W'(d);
    @(posedge clk); #1 wr_en = 0;
  endtask
  task automatic req();
    @(posedge clk); #1 upd_req = 1;
    @(posedge clk); #1 upd_req = 0;
  endtask
  task automatic clr_flags();
    @(posedge clk); #1 sof_clr = 1; udd_clr = 1;
    @(posedge clk); #1 sof_clr = 0; udd_clr = 0;
  endtask
  task automatic wait_com(int c);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (com_act && com_idx == 3'(c)) break;
      tick();
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        done = 1; bad++; total++;
        $display("FAIL watchdog: got=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 ens", ens, 0); chk("R11 com_act", com_act, 0);
    chk("R11 seg_out", seg_out, 0); chk("R11 sof_flag", sof_flag, 0);
    chk("R11 udd_flag", udd_flag, 0); chk("R11 upd_pend", upd_pend, 0);
    chk("R11 irq", irq, 0);
    cmp_on = 1;
    for (int r = 0; r < 8; r++) wr(r, 16'hA5C3 ^ (r * 16'h1357));
    req();
    cyc(10);
    @(negedge clk);
    chk("R9 udd while disabled", udd_flag, 0);
    chk("R9 pend while disabled", upd_pend, 1);
    duty_sel = 3'b011; dead_sel = 3'd2; sof_ie = 1; udd_ie = 1;
    enable = 1;
    cyc(1);
    @(negedge clk);
    chk("R5 ens", ens, 1); chk("R5 com_idx", com_idx, 0); chk("R5 polarity", polarity, 0);
    chk("R8 copy at start", udd_flag, 1);
    ticks(30, 2);
    // R2: duty change in mid-frame keeps current frame length
    wait_com(1);
    duty_sel = 3'b001;
    tick(); cyc(1);
    @(negedge clk);
    chk("R2 frame keeps length", com_idx, 2);
    ticks(20, 1);
    // R8: buffer writes invisible until copy
    for (int r = 0; r < 8; r++) wr(r, 16'h0F0F + r * 16'h0101);
    ticks(6, 1);
    req();
    ticks(10, 1);
    // R7 blink modes
    blink();
    blink_mode = 2'b01; ticks(10, 1);
    blink_mode = 2'b10; ticks(10, 1);
    blink_mode = 2'b11; ticks(6, 1);
    blink();
    ticks(4, 1);
    blink_mode = 2'b00; blink(); ticks(4, 1); blink();
    // other duties and dead times
    duty_sel = 3'b100; dead_sel = 3'd0; ticks(24, 1);
    duty_sel = 3'b000; dead_sel = 3'd7; ticks(24, 1);
    duty_sel = 3'b010; dead_sel = 3'd1; ticks(18, 0);
    duty_sel = 3'b110; ticks(6, 1);
    clr_flags(); sof_ie = 0; ticks(4, 1); udd_ie = 0; clr_flags();
    // R6 disable waits for frame end
    duty_sel = 3'b011; dead_sel = 3'd0;
    ticks(12, 1);
    wait_com(1);
    enable = 0;
    tick(); cyc(1);
    @(negedge clk);
    chk("R6 ens held", ens, 1);
    tick(); tick(); cyc(1);
    @(negedge clk);
    chk("R6 ens after end", ens, 0);
    chk("R6 com_act after end", com_act, 0);
    clr_flags();
    req();
    ticks(5, 2);
    @(negedge clk);
    chk("R9 no completion", udd_flag, 0);
    chk("R9 still pending", upd_pend, 1);
    cyc(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule